// File: doc/BRIEF.md
# Load-Use Scoreboard Interlock

This block sits beside the decode stage of a four-stage in-order integer pipeline (fetch, decode, execute, write; one cycle each). It keeps one pending bit per integer register. A bit is set when a load issues to that register and cleared when the load's data returns. Every cycle it compares the register fields of the instruction held in decode against those bits. It raises `freeze` to hold fetch and decode only when that instruction names a register whose load is still outstanding.

Instructions that touch no pending register keep flowing, including behind a load that has missed the cache. A load that hits returns in its write stage. An instruction directly behind it that reads the loaded register therefore freezes for exactly one clock. Returns clear their bit in the same cycle they arrive, so the waiting instruction is released in that cycle.

Register 0 reads as constant zero. It is never tracked and never causes a hold. The register fields have fixed positions, so the lookup starts before the opcode is decoded. A separate two-bit class input says how the instruction uses its destination field. The block has no states beyond the register-indexed pending bits. There is a single pending-bit update (set on issue, clear on return, set winning), and there are no further state transitions.

Top module: `ldsb_interlock`

## Requirements
- R1: After reset no register is pending and `freeze` is low for any decoded instruction.
- R2: When `iss_valid` is high with `iss_reg`, an instruction in decode in that same cycle that reads `iss_reg` gets `freeze` high. The bit stays pending in later cycles.
- R3: A return on `ret_valid[k]`/`ret_reg` clears the pending bit in the cycle it arrives. A decoded instruction reading only that register has `freeze` low in the return cycle.
- R4: Field positions of `dec_instr`: src2 in bits 25:21, dest in bits 20:16, src1 in bits 15:11, immediate flag in bit 26.
- R5: Register 0 is never marked pending, even when a load issues to it, and a reference to register 0 never raises `freeze`.
- R6: While a load is pending (a cache miss of any length), instructions that name no pending register see `freeze` low.
- R7: Class 2'b00 (register operation) and 2'b11 check src2, and check src1 when the immediate flag is clear. They do not check the dest field.
- R8: With the immediate flag (bit 26) set, bits 15:11 are not checked for any class.
- R9: Class 2'b10 (store) checks src2 and the data register in the dest field. A store naming no pending register is never held.
- R10: When a load issues to a register in the same cycle a return for that register arrives, the register stays pending.
- R11: Class 2'b01 (load) checks src2, src1 when the immediate flag is clear, and its dest. A load whose dest is pending freezes until the earlier load returns.
- R12: With `dec_valid` low, `freeze` is low.
- R13: All return ports clear their registers independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_instr | input | 32 | Instruction word in decode |
| dec_kind | input | 2 | 00 register op, 01 load, 10 store, 11 other |
| iss_valid | input | 1 | A load issues this cycle |
| iss_reg | input | 5 | Destination register of the issuing load |
| ret_valid | input | NRET (2) | Per-port load-return strobe |
| ret_reg | input | NRET*5 (10) | Register filled by each return port, port k at bits 5k+4:5k |
| freeze | output | 1 | Hold fetch and decode this cycle |

## Verification
The assertions assume that a return only arrives for a register that is pending. They also assume that no two loads to one register are outstanding at once, because the pipeline would have held the second load in decode. The random stimulus draws return registers only from the reference model's pending set. It issues new loads only to registers that are free or that return in that same cycle. Directed sequences cover the single-clock load-use hold, long misses with unrelated traffic, the immediate-flag masking, store data checks, issue/return collisions and dual returns.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;

    localparam int REG_W    = 5;
    localparam int NUM_REGS = 1 << REG_W;

    // fixed field positions, shared with the decoder
    localparam int S2_LSB  = 21;
    localparam int DST_LSB = 16;
    localparam int S1_LSB  = 11;
    localparam int IMM_BIT = 26;

    typedef enum logic [1:0] {
        KIND_REGOP = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10,
        KIND_OTHER = 2'b11
    } dec_kind_e;

    typedef enum int {
        SLOT_S2  = 0,
        SLOT_DST = 1,
        SLOT_S1  = 2
    } slot_e;

    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/ldsb_track.sv
module ldsb_track #(
    parameter int NREG = 32,
    parameter int NRET = 2,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_v,
    input  logic [RW-1:0]        set_reg,
    input  logic [NRET-1:0]      clr_v,
    input  logic [NRET*RW-1:0]   clr_reg,
    output logic [NREG-1:0]      pend_q,
    output logic [NREG-1:0]      pend_now
);

    logic [NREG-1:0] pend_d;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_bit
            if (i == 0) begin : g_zero
                assign pend_d[i] = 1'b0;
            end else begin : g_live
                logic set_hit;
                logic [NRET-1:0] clr_hit;
                assign set_hit = set_v && (set_reg == RW'(i));
                for (genvar k = 0; k < NRET; k++) begin : g_port
                    assign clr_hit[k] = clr_v[k] && (clr_reg[k*RW +: RW] == RW'(i));
                end
                // set takes priority over a same-cycle return
                assign pend_d[i] = set_hit || (pend_q[i] && !(|clr_hit));
            end
        end
    endgenerate

    assign pend_now = pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    AST_R0_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]); // R5

    AST_ISSUE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v && set_reg != '0) |=> pend_q[$past(set_reg)]); // R10

    generate
        for (genvar k = 0; k < NRET; k++) begin : g_chk
            AST_RET_OF_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_v[k] && clr_reg[k*RW +: RW] != '0) |-> pend_q[clr_reg[k*RW +: RW]]); // R3

            AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_v[k] && !(set_v && set_reg == clr_reg[k*RW +: RW]))
                |=> !pend_q[$past(clr_reg[k*RW +: RW])]); // R13
        end
    endgenerate

endmodule

// File: rtl/ldsb_probe.sv
module ldsb_probe #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] pend,
    input  logic            en,
    input  logic [RW-1:0]   idx,
    output logic            hit
);

    always_comb begin
        hit = 1'b0;
        if (en && idx != '0) begin
            hit = pend[idx];
        end
    end

endmodule

// File: rtl/ldsb_interlock.sv
module ldsb_interlock
    import ldsb_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int NRET = 2,
    parameter int IW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dec_valid,
    input  logic [IW-1:0]        dec_instr,
    input  logic [1:0]           dec_kind,
    input  logic                 iss_valid,
    input  logic [RW-1:0]        iss_reg,
    input  logic [NRET-1:0]      ret_valid,
    input  logic [NRET*RW-1:0]   ret_reg,
    output logic                 freeze
);

    logic [NREG-1:0]      pend_q;
    logic [NREG-1:0]      pend_now;
    logic [RW-1:0]        slot_idx [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_en;
    logic [NUM_SLOTS-1:0] slot_hit;
    dec_kind_e            kind;
    logic                 imm;

    assign kind = dec_kind_e'(dec_kind);
    assign imm  = dec_instr[IMM_BIT];

    assign slot_idx[SLOT_S2]  = dec_instr[S2_LSB  +: RW];
    assign slot_idx[SLOT_DST] = dec_instr[DST_LSB +: RW];
    assign slot_idx[SLOT_S1]  = dec_instr[S1_LSB  +: RW];

    always_comb begin
        slot_en[SLOT_S2] = 1'b1;
        slot_en[SLOT_S1] = !imm;
        unique case (kind)
            KIND_LOAD:  slot_en[SLOT_DST] = 1'b1;
            KIND_STORE: slot_en[SLOT_DST] = 1'b1;
            KIND_REGOP: slot_en[SLOT_DST] = 1'b0;
            KIND_OTHER: slot_en[SLOT_DST] = 1'b0;
            default:    slot_en[SLOT_DST] = 1'b0;
        endcase
    end

    ldsb_track #(
        .NREG (NREG),
        .NRET (NRET),
        .RW   (RW)
    ) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_v    (iss_valid),
        .set_reg  (iss_reg),
        .clr_v    (ret_valid),
        .clr_reg  (ret_reg),
        .pend_q   (pend_q),
        .pend_now (pend_now)
    );

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            ldsb_probe #(
                .NREG (NREG),
                .RW   (RW)
            ) probe_i (
                .pend (pend_now),
                .en   (slot_en[s]),
                .idx  (slot_idx[s]),
                .hit  (slot_hit[s])
            );
        end
    endgenerate

    assign freeze = dec_valid && (|slot_hit);

    AST_IDLE_NO_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !freeze); // R12

    AST_FREEZE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> (|pend_now)); // R6

    AST_ZERO_FIELDS_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_instr[S2_LSB +: RW] == '0 && dec_instr[DST_LSB +: RW] == '0
         && dec_instr[S1_LSB +: RW] == '0) |-> !freeze); // R5

    AST_WAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && kind == KIND_LOAD && pend_q[dec_instr[DST_LSB +: RW]]
         && !(|ret_valid)) |-> freeze); // R11

endmodule

// File: tb/ldsb_interlock_tb.sv
module ldsb_interlock_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_instr = '0;
    logic [1:0]  dec_kind = 2'b00;
    logic        iss_valid = 1'b0;
    logic [4:0]  iss_reg = '0;
    logic [1:0]  ret_valid = '0;
    logic [9:0]  ret_reg = '0;
    logic        freeze;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [31:0] m_pend = '0;

    always #(CLK_P/2) clk = ~clk;

    ldsb_interlock dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_valid (dec_valid),
        .dec_instr (dec_instr),
        .dec_kind  (dec_kind),
        .iss_valid (iss_valid),
        .iss_reg   (iss_reg),
        .ret_valid (ret_valid),
        .ret_reg   (ret_reg),
        .freeze    (freeze)
    );

    function automatic logic [31:0] mk(bit imm, int s2, int dst, int s1);
        mk = {5'd0, imm, 5'(s2), 5'(dst), 5'(s1), 11'd0};
    endfunction

    function automatic bit eff(int r);
        bit retd;
        retd = (ret_valid[0] && ret_reg[4:0] == 5'(r)) || (ret_valid[1] && ret_reg[9:5] == 5'(r));
        if (r == 0) return 0;
        return (m_pend[r] && !retd) || (iss_valid && iss_reg == 5'(r));
    endfunction

    function automatic bit expect_freeze();
        int s2, dst, s1;
        bit imm, f;
        s2 = dec_instr[25:21]; dst = dec_instr[20:16]; s1 = dec_instr[15:11];
        imm = dec_instr[26];
        f = eff(s2) || (!imm && eff(s1)) || ((dec_kind == 2'b01 || dec_kind == 2'b10) && eff(dst));
        return dec_valid && f;
    endfunction

    task automatic check(string tag);
        bit e;
        e = expect_freeze();
        n_chk++;
        if (freeze !== e) begin
            n_fail++;
            $display("FAIL %s: freeze=%0b expected=%0b at %0t", tag, freeze, e, $time);
        end
    endtask

    task automatic update_model();
        for (int k = 0; k < 2; k++)
            if (ret_valid[k]) m_pend[ret_reg[k*5 +: 5]] = 1'b0;
        if (iss_valid && iss_reg != 0) m_pend[iss_reg] = 1'b1;
    endtask

    task automatic step(bit v, logic [31:0] ins, logic [1:0] k, bit iv, int ir,
                        logic [1:0] rv, int ra, int rb, string tag);
        @(negedge clk);
        dec_valid = v; dec_instr = ins; dec_kind = k;
        iss_valid = iv; iss_reg = 5'(ir);
        ret_valid = rv; ret_reg = {5'(rb), 5'(ra)};
        #1;
        check(tag);
        @(posedge clk);
        update_model();
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: empty after reset
        step(1, mk(0, 5, 6, 7), 2'b01, 0, 0, 2'b00, 0, 0, "R1");
        // R2: instruction right behind a load that reads it
        step(1, mk(0, 5, 1, 2), 2'b00, 1, 5, 2'b00, 0, 0, "R2");
        // R3: hit returns in next cycle, released there
        step(1, mk(0, 5, 1, 2), 2'b00, 0, 0, 2'b01, 5, 0, "R3");
        // R6: long miss on r7, unrelated traffic flows
        step(1, mk(0, 8, 9, 10), 2'b00, 1, 7, 2'b00, 0, 0, "R6");
        for (int i = 0; i < 5; i++)
            step(1, mk(0, 8 + i, 9, 11), 2'b10, 0, 0, 2'b00, 0, 0, "R6");
        step(1, mk(1, 7, 3, 0), 2'b00, 0, 0, 2'b00, 0, 0, "R6");
        step(1, mk(1, 7, 3, 0), 2'b00, 0, 0, 2'b01, 7, 0, "R6");
        // R5: register 0 is never tracked
        step(1, mk(0, 0, 0, 0), 2'b01, 1, 0, 2'b00, 0, 0, "R5");
        step(1, mk(0, 0, 0, 0), 2'b10, 0, 0, 2'b00, 0, 0, "R5");
        // R8, R7, R9 around pending r10
        step(1, mk(0, 1, 2, 3), 2'b00, 1, 10, 2'b00, 0, 0, "R7");
        step(1, mk(1, 1, 2, 10), 2'b00, 0, 0, 2'b00, 0, 0, "R8");
        step(1, mk(1, 1, 2, 10), 2'b10, 0, 0, 2'b00, 0, 0, "R8");
        step(1, mk(0, 1, 2, 10), 2'b00, 0, 0, 2'b00, 0, 0, "R7");
        step(1, mk(0, 1, 10, 2), 2'b00, 0, 0, 2'b00, 0, 0, "R7");
        step(1, mk(1, 1, 10, 0), 2'b10, 0, 0, 2'b00, 0, 0, "R9");
        step(1, mk(1, 3, 4, 0), 2'b10, 0, 0, 2'b00, 0, 0, "R9");
        step(1, mk(1, 1, 10, 0), 2'b10, 0, 0, 2'b01, 10, 0, "R9");
        // R11: load to a pending destination
        step(1, mk(1, 1, 2, 0), 2'b00, 1, 12, 2'b00, 0, 0, "R11");
        step(1, mk(1, 1, 12, 0), 2'b01, 0, 0, 2'b00, 0, 0, "R11");
        step(1, mk(1, 1, 12, 0), 2'b01, 0, 0, 2'b00, 0, 0, "R11");
        step(1, mk(1, 1, 12, 0), 2'b01, 0, 0, 2'b10, 0, 12, "R11");
        // R10: issue and return on one register in one cycle
        step(1, mk(1, 1, 2, 0), 2'b00, 1, 14, 2'b00, 0, 0, "R10");
        step(1, mk(1, 14, 2, 0), 2'b00, 1, 14, 2'b01, 14, 0, "R10");
        step(1, mk(1, 14, 2, 0), 2'b00, 0, 0, 2'b00, 0, 0, "R10");
        step(1, mk(1, 14, 2, 0), 2'b00, 0, 0, 2'b01, 14, 0, "R10");
        // R13: two returns at once
        step(1, mk(1, 1, 2, 0), 2'b00, 1, 16, 2'b00, 0, 0, "R13");
        step(1, mk(1, 1, 2, 0), 2'b00, 1, 17, 2'b00, 0, 0, "R13");
        step(1, mk(0, 16, 2, 17), 2'b00, 0, 0, 2'b00, 0, 0, "R13");
        step(1, mk(0, 16, 2, 17), 2'b00, 0, 0, 2'b11, 16, 17, "R13");
        step(1, mk(0, 16, 17, 17), 2'b01, 0, 0, 2'b00, 0, 0, "R13");
        // R12 and R4
        step(0, mk(0, 20, 20, 20), 2'b01, 1, 20, 2'b00, 0, 0, "R12");
        step(0, mk(0, 20, 20, 20), 2'b10, 0, 0, 2'b00, 0, 0, "R12");
        step(1, mk(0, 20, 1, 2), 2'b00, 0, 0, 2'b01, 20, 0, "R4");
        step(1, mk(0, 1, 2, 3), 2'b00, 1, 21, 2'b00, 0, 0, "R4");
        step(1, mk(0, 1, 2, 21), 2'b00, 0, 0, 2'b00, 0, 0, "R4");
        step(1, mk(0, 1, 21, 2), 2'b11, 0, 0, 2'b00, 0, 0, "R4");
        step(1, mk(0, 1, 2, 21), 2'b00, 0, 0, 2'b01, 21, 0, "R4");
        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            int ra, rb, ir, cnt;
            logic [1:0] rv;
            bit iv;
            rv = 2'b00; ra = 0; rb = 0;
            cnt = 0;
            for (int r = 1; r < 32; r++) if (m_pend[r]) cnt++;
            if (cnt > 0 && ($urandom % 3) == 0) begin
                do ra = 1 + ($urandom % 31); while (!m_pend[ra]);
                rv[0] = 1'b1;
                if (cnt > 1 && ($urandom % 2) == 0) begin
                    do rb = 1 + ($urandom % 31); while (!m_pend[rb] || rb == ra);
                    rv[1] = 1'b1;
                end
            end
            iv = (($urandom % 3) == 0);
            ir = $urandom % 32;
            if (iv && ir != 0 && m_pend[ir] && !(rv[0] && ra == ir) && !(rv[1] && rb == ir))
                iv = 0;
            step(($urandom % 8) != 0,
                 mk($urandom % 2, $urandom % 32, $urandom % 32, $urandom % 32),
                 2'($urandom % 4), iv, ir, rv, ra, rb, "R6");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule